// File: doc/BRIEF.md
# Selectable PRBS and Pattern Generator

This block is a serial test-sequence source. A 4-bit mode code selects one of sixteen sources. Eight of them are pseudo-random sequences made by a linear feedback shift register. The other eight are fixed 8-bit words that repeat. One bit is produced per enabled clock. A polarity flag inverts the pseudo-random sources only. One of the two length-20 sequences also limits runs of zeros.

The mode code and the polarity flag are taken in on a load strobe. The load also restarts the chosen source from a known state, so a receiver or a bench can line up with the stream. The output is one registered bit. A separate error-injection stage can XOR onto this bit further down the datapath.

Top module: `seqgen_top`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), `bit_out` is 0 and the block acts as if mode 0000 with no inversion had been loaded.
- R2: Modes 0000 to 0111 select register lengths 9, 11, 15, 20, 20, 23, 29 and 31, with a second tap at stage 5, 9, 14, 17, 3, 18, 27 and 28 in that order. The XOR of the two tapped stages is the emitted bit and also enters stage 1 while every stage moves one place along. The bit appears on `bit_out` after the enabled edge that computes it.
- R3: Reset and every load set all register stages to 1, so the stream restarts from the same point each time.
- R4: In mode 0100 only, the emitted bit is forced to 1 once the previous `ZRUN_LIMIT` emitted bits (default 14, taken before inversion) were all 0. Forcing changes only the output, not the register.
- R5: Modes 1000 to 1111 repeat the words 00h, FFh, 55h, 33h, 7Fh, 80h, 77h and 88h, sent MSB first. Reset and load restart the word at its MSB.
- R6: When the loaded `invert` is 1, every pseudo-random bit is complemented. The fixed words are never complemented.
- R7: `mode_code` and `invert` are read only on an edge where `load` is 1. Changes to them at any other time have no effect on the stream.
- R8: On an edge with `en` low and `load` low, `bit_out`, the register and the word position all hold.
- R9: A load acts on any edge, whatever the value of `en`. On that edge `bit_out` holds and the stream does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; one bit per enabled edge |
| load | input | 1 | Captures mode and polarity, restarts the source |
| mode_code | input | 4 | Source select, read on load |
| invert | input | 1 | Polarity of the pseudo-random sources, read on load |
| bit_out | output | 1 | Registered serial output |

## Verification
The assertions assume that `load`, `en` and the mode inputs are synchronous and free of X once reset is released. They also assume that `load` has priority, so no advance is expected on a load edge. The stimulus changes every input only on the falling edge. It raises `load` for one cycle at a time, and it scrambles `mode_code` and `invert` only while `load` is low, to show that they are ignored. The bench lowers the zero-run limit so that the forced ones in mode 0100 occur often within a short run.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int REG_W  = 31;
  localparam int CODE_W = 4;
  localparam int PAT_W  = 8;
  localparam int IDX_W  = $clog2(PAT_W);

  typedef logic [CODE_W-1:0] mode_t;
  typedef logic [REG_W-1:0]  lfsr_t;
  typedef logic [PAT_W-1:0]  word_t;

  localparam logic [2:0] ZSUP_SEL = 3'd4;

  // XOR of the far stage (register length) and the near tap
  function automatic logic lfsr_feedback(input lfsr_t st, input logic [2:0] sel);
    logic fb;
    case (sel)
      3'd0:    fb = st[8]  ^ st[4];
      3'd1:    fb = st[10] ^ st[8];
      3'd2:    fb = st[14] ^ st[13];
      3'd3:    fb = st[19] ^ st[16];
      3'd4:    fb = st[19] ^ st[2];
      3'd5:    fb = st[22] ^ st[17];
      3'd6:    fb = st[28] ^ st[26];
      default: fb = st[30] ^ st[27];
    endcase
    return fb;
  endfunction

  function automatic lfsr_t lfsr_advance(input lfsr_t st, input logic [2:0] sel);
    return {st[REG_W-2:0], lfsr_feedback(st, sel)};
  endfunction

  function automatic word_t fixed_word(input logic [2:0] sel);
    word_t w;
    case (sel)
      3'd0:    w = 8'b0000_0000;
      3'd1:    w = 8'b1111_1111;
      3'd2:    w = 8'b0101_0101;
      3'd3:    w = 8'b0011_0011;
      3'd4:    w = 8'b0111_1111;
      3'd5:    w = 8'b1000_0000;
      3'd6:    w = 8'b0111_0111;
      default: w = 8'b1000_1000;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/seqgen_cfg.sv
module seqgen_cfg
  import seqgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_t mode_in,
  input  logic  inv_in,
  output mode_t mode_q,
  output logic  inv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      inv_q  <= 1'b0;
    end else if (load) begin
      mode_q <= mode_in;
      inv_q  <= inv_in;
    end
  end
endmodule

// File: rtl/seqgen_lfsr.sv
module seqgen_lfsr
  import seqgen_pkg::*;
#(
  parameter int ZRUN_LIMIT = 14,
  localparam int ZW = $clog2(ZRUN_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [2:0]    sel,
  input  logic          zsup_en,
  output lfsr_t         state,
  output logic [ZW-1:0] zrun,
  output logic          forced,
  output logic          prbs_bit
);
  logic fb;

  assign fb       = lfsr_feedback(state, sel);
  assign forced   = zsup_en && (zrun == ZW'(ZRUN_LIMIT));
  assign prbs_bit = fb | forced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '1;
      zrun  <= '0;
    end else if (restart) begin
      state <= '1;
      zrun  <= '0;
    end else if (step) begin
      state <= lfsr_advance(state, sel);
      if (prbs_bit)
        zrun <= '0;
      else if (zrun != ZW'(ZRUN_LIMIT))
        zrun <= zrun + 1'b1;
    end
  end
endmodule

// File: rtl/seqgen_pattern.sv
module seqgen_pattern
  import seqgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [2:0]       sel,
  output logic [IDX_W-1:0] idx,
  output logic             pat_bit
);
  word_t word;

  assign word    = fixed_word(sel);
  assign pat_bit = word[IDX_W'(PAT_W - 1) - idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (restart)
      idx <= '0;
    else if (step)
      idx <= idx + 1'b1;
  end
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
#(
  parameter int ZRUN_LIMIT = 14,
  localparam int ZW = $clog2(ZRUN_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       load,
  input  logic [3:0] mode_code,
  input  logic       invert,
  output logic       bit_out
);
  mode_t            mode_q;
  logic             inv_q;
  logic             adv;
  logic             is_fixed;
  logic             zsup_en;
  lfsr_t            lfsr_state;
  logic [ZW-1:0]    zrun;
  logic             forced;
  logic             prbs_bit;
  logic [IDX_W-1:0] pat_idx;
  logic             pat_bit;
  logic             next_bit;
  logic             bit_q;

  assign adv      = en && !load;
  assign is_fixed = mode_q[CODE_W-1];
  assign zsup_en  = (mode_q == {1'b0, ZSUP_SEL});

  seqgen_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .mode_in (mode_code),
    .inv_in  (invert),
    .mode_q  (mode_q),
    .inv_q   (inv_q)
  );

  seqgen_lfsr #(.ZRUN_LIMIT(ZRUN_LIMIT)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load),
    .step     (adv && !is_fixed),
    .sel      (mode_q[2:0]),
    .zsup_en  (zsup_en),
    .state    (lfsr_state),
    .zrun     (zrun),
    .forced   (forced),
    .prbs_bit (prbs_bit)
  );

  seqgen_pattern u_pat (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .step    (adv && is_fixed),
    .sel     (mode_q[2:0]),
    .idx     (pat_idx),
    .pat_bit (pat_bit)
  );

  assign next_bit = is_fixed ? pat_bit : (prbs_bit ^ inv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bit_q <= 1'b0;
    else if (adv)
      bit_q <= next_bit;
  end

  assign bit_out = bit_q;
endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk
  import seqgen_pkg::*;
#(
  parameter int ZRUN_LIMIT = 14,
  localparam int ZW = $clog2(ZRUN_LIMIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             load,
  input logic [3:0]       mode_code,
  input logic             invert,
  input logic             bit_out,
  input mode_t            mode_q,
  input logic             inv_q,
  input lfsr_t            lfsr_state,
  input logic [ZW-1:0]    zrun,
  input logic             forced,
  input logic [IDX_W-1:0] pat_idx,
  input logic             pat_bit,
  input logic             adv
);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(bit_out) && $stable(lfsr_state) && $stable(pat_idx)));

  // R9
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(bit_out));

  // R7
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q == $past(mode_code) && inv_q == $past(invert)));

  // R7
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mode_q) && $stable(inv_q)));

  // R3
  reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((&lfsr_state) && pat_idx == '0 && zrun == '0));

  // R5
  pat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q[CODE_W-1]) |=> pat_idx == IDX_W'($past(pat_idx) + 1'b1));

  // R6
  fixed_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q[CODE_W-1]) |=> bit_out == $past(pat_bit));

  // R4
  zsup_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && forced) |=> bit_out == !$past(inv_q));

  // R4
  zrun_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= ZW'(ZRUN_LIMIT));
endmodule

bind seqgen_top seqgen_chk #(.ZRUN_LIMIT(ZRUN_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .load       (load),
  .mode_code  (mode_code),
  .invert     (invert),
  .bit_out    (bit_out),
  .mode_q     (mode_q),
  .inv_q      (inv_q),
  .lfsr_state (lfsr_state),
  .zrun       (zrun),
  .forced     (forced),
  .pat_idx    (pat_idx),
  .pat_bit    (pat_bit),
  .adv        (adv)
);

// File: tb/seqgen_top_bench.sv
module seqgen_top_bench;
  localparam int CLK_P = 10;
  localparam int ZLIM  = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [3:0] mode_code = 4'd0;
  logic       invert = 1'b0;
  logic       bit_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit    m_reg [1:31];
  int    m_code = 0;
  bit    m_inv = 0;
  int    m_zeros = 0;
  int    m_idx = 0;
  int    m_since = 0;
  string tag_force = "";

  bit    exp_q [$];
  string tag_q [$];

  byte unsigned words [8] = '{8'h00, 8'hFF, 8'h55, 8'h33, 8'h7F, 8'h80, 8'h77, 8'h88};
  int len_tbl [8] = '{9, 11, 15, 20, 20, 23, 29, 31};
  int tap_tbl [8] = '{5, 9, 14, 17, 3, 18, 27, 28};

  seqgen_top #(.ZRUN_LIMIT(ZLIM)) u_seqgen_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (load),
    .mode_code (mode_code),
    .invert    (invert),
    .bit_out   (bit_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic act, input logic expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic m_restart();
    for (int k = 1; k <= 31; k++) m_reg[k] = 1'b1;
    m_zeros = 0;
    m_idx = 0;
    m_since = 0;
  endtask

  task automatic m_next(output bit b, output string t);
    bit raw;
    if (m_code >= 8) begin
      b = words[m_code-8][7-m_idx];
      m_idx = (m_idx + 1) % 8;
      t = m_inv ? "R6" : "R5";
    end else begin
      raw = m_reg[len_tbl[m_code]] ^ m_reg[tap_tbl[m_code]];
      for (int k = 31; k >= 2; k--) m_reg[k] = m_reg[k-1];
      m_reg[1] = raw;
      if (m_code == 4 && m_zeros == ZLIM) raw = 1'b1;
      if (raw) m_zeros = 0;
      else if (m_zeros < ZLIM) m_zeros++;
      b = raw ^ m_inv;
      if (m_code == 4) t = "R4";
      else if (m_inv) t = "R6";
      else if (m_since < 31) t = "R3";
      else t = "R2";
    end
    m_since++;
    if (tag_force != "") t = tag_force;
  endtask

  // driver: one enabled bit per cycle
  task automatic run(input int n);
    bit b;
    string t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b1;
      m_next(b, t);
      exp_q.push_back(b);
      tag_q.push_back(t);
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic do_load(input int code, input bit inv, input bit en_val);
    logic prev;
    @(negedge clk);
    load = 1'b1;
    en = en_val;
    mode_code = 4'(code);
    invert = inv;
    prev = bit_out;
    @(negedge clk);
    check(bit_out === prev, "R9", bit_out, prev);
    load = 1'b0;
    en = 1'b0;
    m_code = code;
    m_inv = inv;
    m_restart();
  endtask

  task automatic idle(input int n);
    logic prev;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b0;
      mode_code = 4'(i * 5 + 3);
      invert = ~invert;
      prev = bit_out;
      @(negedge clk);
      check(bit_out === prev, "R8", bit_out, prev);
    end
  endtask

  // monitor: pop and compare after every advancing edge
  initial begin
    bit    e;
    string t;
    forever begin
      @(posedge clk);
      if (rst_n && en && !load) begin
        #(CLK_P/4);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", bit_out, 1'bx);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(bit_out === e, t, bit_out, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_restart();
    repeat (3) @(negedge clk);
    // R1: reset value
    check(bit_out === 1'b0, "R1", bit_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_out === 1'b0, "R1", bit_out, 1'b0);
    tag_force = "R1";
    run(40);
    tag_force = "";

    // R2, R3, R4: every pseudo-random mode
    for (int c = 0; c < 8; c++) begin
      do_load(c, 1'b0, 1'b0);
      run(c == 4 ? 3000 : 300);
    end

    // R6: inverted pseudo-random, fixed words ignore invert
    do_load(0, 1'b1, 1'b0);
    run(200);
    do_load(5, 1'b1, 1'b1);
    run(100);
    for (int c = 8; c < 16; c++) begin
      do_load(c, c[0], 1'b0);
      run(20);
    end

    // R7, R8: ignored inputs and held output
    do_load(2, 1'b0, 1'b0);
    run(50);
    idle(10);
    run(50);
    do_load(11, 1'b0, 1'b0);
    run(5);
    idle(6);
    run(20);

    // R9: load mid-stream with enable high restarts
    do_load(7, 1'b0, 1'b1);
    run(80);

    // R4 with inversion
    do_load(4, 1'b1, 1'b0);
    run(2000);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", 1'b0, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule